// File: doc/BRIEF.md
# SIMD Lane Shift and Rotate Unit

This block shifts or rotates a 64-bit word treated as a set of equal-width lanes. A caller presents an operand, an 8-bit unsigned count, an operation code and a lane-size code with a one-cycle valid strobe. One clock later the unit returns the result with a negative flag and a zero flag for each lane. Each lane is processed on its own, and no bit crosses from one lane into the next.

Counts larger than the lane can hold are handled in a fixed way. Logical shifts return zero, and the arithmetic right shift fills the lane with its sign bit. Rotates take the count modulo the lane width. A lane-size code with no defined meaning raises a one-cycle error flag and does not produce a result.

Top module: `simd_shift_rot`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. `result` and both flag buses are registered at that same edge and hold their values while `in_valid` is low.
- R2: The op code 0 selects a logical left shift in each lane. A count above lane width minus one makes that lane all zero.
- R3: The op code 1 selects a logical right shift in each lane, with zeros entering from the top. A count above lane width minus one makes that lane all zero.
- R4: The op code 2 selects an arithmetic right shift in each lane, with copies of the lane's sign bit entering from the top. A count above lane width minus one fills the lane with its sign bit.
- R5: The op code 3 rotates each lane right by the count modulo the lane width, which is the low 4, 5 or 6 count bits. A masked count of zero returns the lane unchanged.
- R6: The size code 0 selects four 16-bit lanes, code 1 selects two 32-bit lanes and code 2 selects one 64-bit lane. Lane k occupies result bits [k*W +: W], and no lane's result depends on another lane's input bits.
- R7: Flag bit k of `neg_flags` equals the top bit of lane k's result, and flag bit k of `zero_flags` is set when that lane's result is zero. Flag bits for lanes absent at the current size are 0. In 64-bit mode only bit 0 is used.
- R8: The size code 3 sets `undef_err` for the one output cycle. In that cycle `result`, `neg_flags` and `zero_flags` are all zero.
- R9: After reset `out_valid` and `undef_err` are 0, and `result` and both flag buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 2 | 0 SLL, 1 SRL, 2 SRA, 3 ROR |
| lane_size | input | 2 | 0 = 16-bit, 1 = 32-bit, 2 = 64-bit, 3 = undefined |
| count | input | 8 | Unsigned shift or rotate amount |
| operand | input | 64 | Source word |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted or rotated word |
| neg_flags | output | 4 | Per-lane negative flags |
| zero_flags | output | 4 | Per-lane zero flags |
| undef_err | output | 1 | Undefined lane size was requested |

## Verification
The bench sweeps every count from 0 to 255 across all operations, all size codes and operands whose lanes differ from one another. This reaches the exact boundary of lane width minus one for each size. A design that wraps an out-of-range shift count modulo the width instead of saturating would produce non-zero lanes or wrong sign fill. A design that leaks bits across lane boundaries would corrupt the lane next to a boundary that carries a set bit. Rotates with a masked count of zero catch a wrap that yields zero instead of the input, and the 32-bit and 64-bit sweeps catch stray flags in absent lanes.

// File: rtl/simd_shift_rot.sv
module simd_shift_rot #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op,
  input  logic [1:0]       lane_size,
  input  logic [CNT_W-1:0] count,
  input  logic [63:0]      operand,
  output logic             out_valid,
  output logic [63:0]      result,
  output logic [3:0]       neg_flags,
  output logic [3:0]       zero_flags,
  output logic             undef_err
);

  localparam logic [1:0] OP_SRA = 2'd2;
  localparam logic [1:0] OP_ROR = 2'd3;

  // lane is left-aligned so saturation falls out of the 64-bit shift
  function automatic logic [63:0] lane_fn(input logic [63:0] x, input int w,
                                          input logic [1:0] o, input logic [CNT_W-1:0] c);
    logic [63:0] xa, t;
    int rc;
    xa = x << (64 - w);
    rc = int'(c) & (w - 1);
    case (o)
      2'd0:    t = xa << c;
      2'd1:    t = xa >> c;
      2'd2:    t = $signed(xa) >>> c;
      default: t = (xa >> rc) | (xa << (w - rc));
    endcase
    return t >> (64 - w);
  endfunction

  logic [15:0] l16 [4];
  logic [31:0] l32 [2];
  logic [63:0] l64;

  for (genvar i = 0; i < 4; i++) begin : g_h
    assign l16[i] = 16'(lane_fn({48'b0, operand[16*i +: 16]}, 16, op, count));
  end
  for (genvar i = 0; i < 2; i++) begin : g_w
    assign l32[i] = 32'(lane_fn({32'b0, operand[32*i +: 32]}, 32, op, count));
  end
  assign l64 = lane_fn(operand, 64, op, count);

  logic [63:0] n_res;
  logic [3:0]  n_neg, n_zero;

  always_comb begin
    n_res  = '0;
    n_neg  = '0;
    n_zero = '0;
    case (lane_size)
      2'd0: begin
        n_res = {l16[3], l16[2], l16[1], l16[0]};
        for (int i = 0; i < 4; i++) begin
          n_neg[i]  = l16[i][15];
          n_zero[i] = (l16[i] == '0);
        end
      end
      2'd1: begin
        n_res = {l32[1], l32[0]};
        for (int i = 0; i < 2; i++) begin
          n_neg[i]  = l32[i][31];
          n_zero[i] = (l32[i] == '0);
        end
      end
      2'd2: begin
        n_res     = l64;
        n_neg[0]  = l64[63];
        n_zero[0] = (l64 == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      undef_err  <= 1'b0;
      result     <= '0;
      neg_flags  <= '0;
      zero_flags <= '0;
    end else begin
      out_valid <= in_valid;
      undef_err <= in_valid && (lane_size == 2'd3);
      if (in_valid) begin
        result     <= n_res;
        neg_flags  <= n_neg;
        zero_flags <= n_zero;
      end
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(neg_flags) && $stable(zero_flags));
  p_signfill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SRA && lane_size == 2'd2 && count > 63)
      |=> result == {64{$past(operand[63])}});
  p_rot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_ROR && lane_size == 2'd0 && count[3:0] == 4'd0)
      |=> result == $past(operand));
  p_absent_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_size == 2'd1) |=> neg_flags[3:2] == 2'b0 && zero_flags[3:2] == 2'b0);
  p_flags64_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_size == 2'd2)
      |=> zero_flags == {3'b0, result == 64'd0} && neg_flags == {3'b0, result[63]});
  p_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_size == 2'd3)
      |=> undef_err && result == '0 && neg_flags == '0 && zero_flags == '0);

endmodule

// File: tb/simd_shift_rot_test.sv
`timescale 1ns/1ps
module simd_shift_rot_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] op = '0, lane_size = '0;
  logic [7:0] count = '0;
  logic [63:0] operand = '0;
  logic out_valid, undef_err;
  logic [63:0] result;
  logic [3:0] neg_flags, zero_flags;

  int total = 0, bad = 0;

  simd_shift_rot uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .lane_size(lane_size), .count(count), .operand(operand), .out_valid(out_valid),
    .result(result), .neg_flags(neg_flags), .zero_flags(zero_flags), .undef_err(undef_err));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [63:0] x, input int w,
                                        input int o, input int c);
    logic [63:0] m, r;
    logic sgn;
    int rc;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    x = x & m;
    sgn = x[w-1];
    case (o)
      0: r = (c >= w) ? 64'd0 : ((x << c) & m);
      1: r = (c >= w) ? 64'd0 : (x >> c);
      2: if (c >= w) r = sgn ? m : 64'd0;
         else r = (x >> c) | (sgn ? (m & ~(m >> c)) : 64'd0);
      default: begin
        rc = c % w;
        r = (rc == 0) ? x : (((x >> rc) | (x << (w - rc))) & m);
      end
    endcase
    return r;
  endfunction

  task automatic run(input int o, input int s, input int c, input logic [63:0] x);
    logic [63:0] er, lr;
    logic [3:0] en, ez;
    int w, n;
    string tg;
    op = 2'(o); lane_size = 2'(s); count = 8'(c); operand = x; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    er = '0; en = '0; ez = '0;
    if (s != 3) begin
      w = 16 << s; n = 64 / w;
      for (int k = 0; k < n; k++) begin
        lr = model(x >> (k * w), w, o, c);
        er = er | (lr << (k * w));
        en[k] = lr[w-1];
        ez[k] = (lr == 64'd0);
      end
    end
    case (o)
      0: tg = "R2/R6";
      1: tg = "R3/R6";
      2: tg = "R4/R6";
      default: tg = "R5/R6";
    endcase
    if (s == 3) tg = "R8";
    chk("R1 out_valid", {63'b0, out_valid}, 64'd1);
    chk(tg, result, er);
    chk("R7 neg", {60'b0, neg_flags}, {60'b0, en});
    chk("R7 zero", {60'b0, zero_flags}, {60'b0, ez});
    chk("R8 undef_err", {63'b0, undef_err}, {63'b0, s == 3});
  endtask

  logic [63:0] pats [6];

  initial begin
    logic [63:0] held;
    pats[0] = 64'h8001_7FFF_0000_FFFF;
    pats[1] = 64'h0123_4567_89AB_CDEF;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0000_0000_0000_0000;
    pats[4] = 64'h8000_0000_0000_0001;
    pats[5] = 64'h5A5A_A5A5_F00F_0FF0;
    repeat (3) @(negedge clk);
    chk("R9 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R9 undef_err", {63'b0, undef_err}, 64'd0);
    chk("R9 result", result, 64'd0);
    chk("R9 flags", {56'b0, neg_flags, zero_flags}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int c = 0; c < 256; c++)
            run(o, s, c, pats[p]);
    run(3, 0, 0, 64'h1234_5678_9ABC_DEF0);
    held = result;
    operand = 64'hDEAD_BEEF_0000_1111;
    @(negedge clk);
    chk("R1 out_valid idle", {63'b0, out_valid}, 64'd0);
    chk("R1 hold", result, held);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule